// File: doc/BRIEF.md
# GPIO Bank Edge Interrupt Controller

This block is one bank of general-purpose pins that can raise an interrupt on a pin's rising edge, its falling edge, or both. Software uses a small register port to set pin direction and output data, to enable or disable each edge, and to read and acknowledge pending flags. The per-pin pending flags are ORed into one bank interrupt line.

Edge enables are never written directly. Each edge has a pair of set and clear registers, so one pin can be changed without a read-modify-write. Edge detection watches the level that actually appears at the pin, after two synchronizing flops. A pin that the block itself drives therefore raises an interrupt when software toggles it. A low-power request stops new flags from being set and freezes the driven pin state.

Top module: `gpio_edge_bank`

## Requirements
- R1: Register map by `addr`: 0 direction (1 = output), 1 output data, 2 rising-set, 3 rising-clear, 4 falling-set, 5 falling-clear, 6 status, 7 synchronized pin level. Reads of 2 or 3 return the rising enables and reads of 4 or 5 return the falling enables. Writing 1 to a bit of address 2 enables rising detection for that pin. A 0 bit leaves that pin's enable unchanged.
- R2: Writing 1 to a bit of address 4 enables falling detection for that pin. A pin with both enables set flags on every edge.
- R3: Writing 1 to a bit of address 3 or 5 disables that edge for that pin. A 0 bit leaves it unchanged. A pin with both edges cleared sets no flag.
- R4: A read of address 6 shows 1 for each pin with a pending flag and 0 for each pin without one. `irq` is high exactly while any flag is pending.
- R5: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged.
- R6: Detection uses the level on `pin_in` whatever the pin's direction. A write to the output data that toggles a pin configured as an output, and looped back through the pad, sets its flag when that edge is enabled.
- R7: While `lp_req` is high, no new flag is set and writes to addresses 0 and 1 are ignored, so `pin_out` and `pin_oe` hold their values.
- R8: When an edge is detected in the same cycle as a write of 1 to its status bit, the flag stays set.
- R9: A pin level change that happens while `lp_req` is high is not reported as an edge after `lp_req` falls.
- R10: A pin change first shows in status after the third rising clock edge following it. Two edges go to synchronization and one to the flag register.
- R11: After reset, every register, `pin_out`, `pin_oe` and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | N | Write data, one bit per pin |
| rdata | output | N | Read data for `addr` (combinational) |
| pin_in | input | N | Level present at the pins |
| pin_out | output | N | Output data driven to the pins |
| pin_oe | output | N | Output enable per pin |
| lp_req | input | 1 | Low-power request |
| irq | output | 1 | Bank interrupt, high while any flag pends |

## Verification
The bench sweeps every pin with every combination of the two enables and both edge directions. A swapped or cross-wired enable therefore shows up as a missing or extra flag. It times the flag to the exact cycle, which catches a missing or extra synchronizer stage. It drives an edge into the same cycle as an acknowledge, so a design where the clear wins loses the flag. The low-power checks change a pin during low power and then release it. A design that keeps stale edge history reports an edge that never happened. A design that accepts data writes during low power moves the held outputs.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  input  logic         lp_req,
  output logic         irq
);
  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_RSET = 3'd2, A_RCLR = 3'd3,
                         A_FSET = 3'd4, A_FCLR = 3'd5, A_STAT = 3'd6, A_LVL = 3'd7;

  logic [N-1:0] dir_r, out_r, rise_en, fall_en, stat, s1, s2, prev;

  wire          wr_cfg = wr_en & ~lp_req;
  wire [N-1:0]  clr    = (wr_en && addr == A_STAT) ? wdata : '0;
  wire [N-1:0]  hit    = ((s2 & ~prev & rise_en) | (~s2 & prev & fall_en)) & {N{~lp_req}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_r <= '0;
      out_r <= '0;
    end else if (wr_cfg) begin
      if (addr == A_DIR) dir_r <= wdata;
      if (addr == A_OUT) out_r <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
    end else if (wr_en) begin
      case (addr)
        A_RSET:  rise_en <= rise_en | wdata;
        A_RCLR:  rise_en <= rise_en & ~wdata;
        A_FSET:  fall_en <= fall_en | wdata;
        A_FCLR:  fall_en <= fall_en & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | hit;
  end

  always_comb begin
    case (addr)
      A_DIR:          rdata = dir_r;
      A_OUT:          rdata = out_r;
      A_RSET, A_RCLR: rdata = rise_en;
      A_FSET, A_FCLR: rdata = fall_en;
      A_STAT:         rdata = stat;
      default:        rdata = s2;
    endcase
  end

  assign pin_out = out_r;
  assign pin_oe  = dir_r;
  assign irq     = |stat;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [N-1:0] wdata,
  input logic         lp_req,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] rise_en,
  input logic [N-1:0] fall_en,
  input logic [N-1:0] stat
);
  p_rise_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ((rise_en & $past(wdata)) == $past(wdata)));

  p_fall_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> ((fall_en & $past(wdata)) == $past(wdata)));

  p_rise_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> ((rise_en & $past(wdata)) == '0));

  p_fall_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> ((fall_en & $past(wdata)) == '0));

  p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6) |=> ((~$past(wdata) & $past(stat) & ~stat) == '0));

  p_lp_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |=> ((stat & ~$past(stat)) == '0));

  p_lp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .lp_req(lp_req), .pin_out(pin_out), .pin_oe(pin_oe),
  .rise_en(rise_en), .fall_en(fall_en), .stat(stat)
);

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, lp_req = 0;
  logic [2:0] addr = 0;
  logic [N-1:0] wdata = 0, rdata, pin_in, pin_out, pin_oe, ext = 0;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_bank #(.N(N)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .lp_req(lp_req), .irq(irq));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    #1;
    rd(3'd6, v); chk("R11 status", v, '0);
    chk("R11 irq", {{(N-1){1'b0}}, irq}, '0);
    chk("R11 oe", pin_oe, '0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R3 R4 R5: sweep pins x enable configs x edges
    for (int p = 0; p < N; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [N-1:0] m;
        m = N'(1) << p;
        wr(3'd3, '1); wr(3'd5, '1); wr(3'd6, '1);
        if (cfg[0]) wr(3'd2, m);
        if (cfg[1]) wr(3'd4, m);
        rd(3'd2, v); chk("R1 rise enable", v, cfg[0] ? m : '0);
        rd(3'd4, v); chk("R2 fall enable", v, cfg[1] ? m : '0);
        @(negedge clk); ext = ext | m; waitc(4);
        rd(3'd6, v); chk("R4 rise flag", v, cfg[0] ? m : '0);
        chk("R4 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, cfg[0]});
        wr(3'd6, ~m);
        rd(3'd6, v); chk("R5 write zero keeps", v, cfg[0] ? m : '0);
        wr(3'd6, m);
        rd(3'd6, v); chk("R5 write one clears", v, '0);
        @(negedge clk); ext = ext & ~m; waitc(4);
        rd(3'd6, v); chk("R3 fall flag", v, cfg[1] ? m : '0);
      end
    end
    wr(3'd3, '1); wr(3'd5, '1); wr(3'd6, '1);
    rd(3'd2, v); chk("R3 rise cleared", v, '0);

    // R10 latency
    wr(3'd2, 4'b0001);
    @(negedge clk); ext = 4'b0001;
    @(negedge clk); rd(3'd6, v); chk("R10 after edge 1", v, '0);
    @(negedge clk); rd(3'd6, v); chk("R10 after edge 2", v, '0);
    @(negedge clk); rd(3'd6, v); chk("R10 after edge 3", v, 4'b0001);

    // R8 edge vs clear in same cycle
    wr(3'd4, 4'b0001);
    @(negedge clk); ext = 4'b0000;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 3'd6; wdata = 4'b0001;
    @(negedge clk); wr_en = 0;
    rd(3'd6, v); chk("R8 edge wins", v, 4'b0001);
    wr(3'd6, '1);

    // R6 output-driven pin
    wr(3'd2, 4'b1000); wr(3'd0, 4'b1000); waitc(4); wr(3'd6, '1);
    wr(3'd1, 4'b1000); waitc(4);
    rd(3'd6, v); chk("R6 output toggle flags", v, 4'b1000);
    wr(3'd6, '1);

    // R7 R9 low power
    wr(3'd2, 4'b0010);
    @(negedge clk); lp_req = 1;
    wr(3'd0, 4'b0000); wr(3'd1, 4'b0000);
    chk("R7 oe held", pin_oe, 4'b1000);
    chk("R7 out held", pin_out, 4'b1000);
    @(negedge clk); ext = 4'b0010; waitc(6);
    rd(3'd6, v); chk("R7 no flag in low power", v, '0);
    @(negedge clk); lp_req = 0; waitc(6);
    rd(3'd6, v); chk("R9 no late edge", v, '0);
    @(negedge clk); ext = 4'b0000; waitc(3);
    @(negedge clk); ext = 4'b0010; waitc(4);
    rd(3'd6, v); chk("R9 edges resume", v, 4'b0010);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule